// File: doc/BRIEF.md
# Six-Digit Multiplexed Display Scanner

This block drives a six-digit multiplexed numeric display from six BCD digits that an upstream stage holds steady. A three-bit twisted-ring (Johnson) sequencer with six states picks one digit at a time. It starts at the most significant digit and steps toward the least significant on each scan tick, then wraps back to the most significant. For the selected digit the block presents a one-hot digit strobe, the raw BCD code and a seven-segment pattern.

Each step opens with a blanking gap. The gap lasts a set number of system clocks. During the gap the strobes and the segments are dark, but the BCD output already carries the new digit, so it is settled before the strobe comes on. Leading zeros can be suppressed on the segments. The BCD and strobe outputs never carry this suppression.

A hold input, active low, parks the scan on the most significant digit. While it is held, the segments stay dark and ticks are ignored. Releasing it lets scanning resume from that digit.

Top module: `display_scanner`

## Requirements
- R1: Once reset is released, the scan sits on the most significant digit with no gap running: strobe_o is 6'b100000 and bcd_o equals digits_i[23:20].
- R2: Each scan_tick while hold_n is high moves the scan one digit toward the least significant. The order is slot 0 to slot 5, then back to slot 0. Slot k reads digits_i[(5-k)*4 +: 4] and lights strobe_o[5-k], so strobe_o never has more than one bit set.
- R3: In the GAP_CYC clock cycles that follow each accepted tick, strobe_o and seg_o are both all-zero. After the gap, the strobe for the new slot is lit.
- R4: bcd_o presents the new slot's digit in the first cycle of the gap, and it holds that value until the next accepted tick or hold.
- R5: seg_o is active-high, with bit 0 = segment a through bit 6 = segment g. The digits 0 to 9 map to 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex).
- R6: When lz_off is low, the segments of a zero digit go dark only if every more significant digit is also zero. The least significant digit (slot 5) is never suppressed. Strobes are not affected by this suppression.
- R7: When lz_off is high, leading zeros show as the 0 pattern. bcd_o is the selected digit whatever lz_off is.
- R8: While hold_n is low, seg_o is all-zero and scan_tick has no effect. From the next clock on, the scan is on slot 0 with strobe_o = 6'b100000 and bcd_o showing the most significant digit. After release, the first tick moves to slot 1.
- R9: Digit codes 10 to 15 give all-zero segments, while bcd_o still shows the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scan_tick | input | 1 | One-cycle request to step to the next digit |
| hold_n | input | 1 | Active low: park on the most significant digit, segments dark |
| lz_off | input | 1 | High disables leading-zero suppression |
| digits_i | input | 24 | Six BCD digits, most significant in bits 23:20 |
| strobe_o | output | 6 | One-hot digit strobe, bit 5 = most significant |
| bcd_o | output | 4 | BCD code of the selected digit |
| seg_o | output | 7 | Segment pattern, bit 0 = a ... bit 6 = g |

## Verification
The scan is driven with ticks spaced wider than the gap, with ticks landing inside a running gap, and with back-to-back ticks. These patterns separate the case where the gap reloads from the case where the slot sequence simply advances. The digit sets compare all-zero values, values with only leading zeros, and values with an embedded zero after a non-zero digit. Together they show whether suppression stops at the first non-zero digit, and whether it spares the least significant digit. Further runs cover lz_off high, holds asserted in mid-scan with ticks present, and codes 10 to 15. These isolate the segment-only effects from the BCD and strobe paths.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int NUM_DIG = 6;
  localparam int BCD_W   = 4;
  localparam int SEG_W   = 7;
  localparam int SLOT_W  = 3;

  // seven-segment pattern, bit0 = a .. bit6 = g, active high
  function automatic logic [SEG_W-1:0] bcd_to_seg(input logic [BCD_W-1:0] d);
    logic [SEG_W-1:0] s;
    case (d)
      4'd0: s = 7'h3F;
      4'd1: s = 7'h06;
      4'd2: s = 7'h5B;
      4'd3: s = 7'h4F;
      4'd4: s = 7'h66;
      4'd5: s = 7'h6D;
      4'd6: s = 7'h7D;
      4'd7: s = 7'h07;
      4'd8: s = 7'h7F;
      4'd9: s = 7'h6F;
      default: s = '0;
    endcase
    return s;
  endfunction

  // twisted-ring state to slot number (0 = most significant digit)
  function automatic logic [SLOT_W-1:0] ring_to_slot(input logic [2:0] r);
    logic [SLOT_W-1:0] k;
    case (r)
      3'b000: k = 3'd0;
      3'b001: k = 3'd1;
      3'b011: k = 3'd2;
      3'b111: k = 3'd3;
      3'b110: k = 3'd4;
      3'b100: k = 3'd5;
      default: k = 3'd0;
    endcase
    return k;
  endfunction

  function automatic logic [2:0] ring_next(input logic [2:0] r);
    return {r[1:0], ~r[2]};
  endfunction
endpackage

// File: rtl/scan_seq.sv
module scan_seq
  import scan_pkg::*;
#(
  parameter int GAP_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_tick,
  input  logic              hold_n,
  output logic [SLOT_W-1:0] slot,
  output logic              gap_on
);
  localparam int CNT_W = $clog2(GAP_CYC + 1) + 1;
  localparam logic [CNT_W-1:0] GAP_LOAD = CNT_W'(GAP_CYC);

  logic [2:0]       ring_q;
  logic [CNT_W-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring_q <= 3'b000;
      gap_q  <= '0;
    end else if (!hold_n) begin
      ring_q <= 3'b000;
      gap_q  <= '0;
    end else if (scan_tick) begin
      ring_q <= ring_next(ring_q);
      gap_q  <= GAP_LOAD;
    end else if (gap_q != '0) begin
      gap_q <= gap_q - 1'b1;
    end
  end

  assign slot   = ring_to_slot(ring_q);
  assign gap_on = (gap_q != '0);
endmodule

// File: rtl/digit_pick.sv
module digit_pick
  import scan_pkg::*;
(
  input  logic [NUM_DIG*BCD_W-1:0] digits_i,
  input  logic [SLOT_W-1:0]        slot,
  input  logic                     lz_off,
  output logic [BCD_W-1:0]         bcd,
  output logic                     lead_zero
);
  logic [NUM_DIG-1:0] pre_zero;
  logic [NUM_DIG-1:0] sel;
  logic [BCD_W-1:0]   dig [NUM_DIG];

  for (genvar k = 0; k < NUM_DIG; k++) begin : g_slot
    assign dig[k] = digits_i[(NUM_DIG-1-k)*BCD_W +: BCD_W];
    assign sel[k] = (slot == SLOT_W'(k));
    if (k == 0) begin : g_first
      assign pre_zero[k] = (dig[k] == '0);
    end else begin : g_rest
      assign pre_zero[k] = pre_zero[k-1] && (dig[k] == '0);
    end
  end

  always_comb begin
    bcd = '0;
    for (int k = 0; k < NUM_DIG; k++) begin
      if (sel[k]) bcd = dig[k];
    end
  end

  assign lead_zero = !lz_off && !sel[NUM_DIG-1] && |(pre_zero & sel);
endmodule

// File: rtl/display_scanner.sv
module display_scanner
  import scan_pkg::*;
#(
  parameter int GAP_CYC = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     scan_tick,
  input  logic                     hold_n,
  input  logic                     lz_off,
  input  logic [NUM_DIG*BCD_W-1:0] digits_i,
  output logic [NUM_DIG-1:0]       strobe_o,
  output logic [BCD_W-1:0]         bcd_o,
  output logic [SEG_W-1:0]         seg_o
);
  logic [SLOT_W-1:0] slot_q;
  logic              gap_on;
  logic              lead_zero;
  logic              seg_dark;

  scan_seq #(.GAP_CYC(GAP_CYC)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .scan_tick(scan_tick),
    .hold_n   (hold_n),
    .slot     (slot_q),
    .gap_on   (gap_on)
  );

  digit_pick u_pick (
    .digits_i (digits_i),
    .slot     (slot_q),
    .lz_off   (lz_off),
    .bcd      (bcd_o),
    .lead_zero(lead_zero)
  );

  for (genvar k = 0; k < NUM_DIG; k++) begin : g_strobe
    assign strobe_o[NUM_DIG-1-k] = !gap_on && (slot_q == SLOT_W'(k));
  end

  assign seg_dark = gap_on || !hold_n || lead_zero;
  assign seg_o    = seg_dark ? '0 : bcd_to_seg(bcd_o);
endmodule

// File: rtl/scan_chk.sv
module scan_chk #(
  parameter int GAP_CYC = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scan_tick,
  input logic       hold_n,
  input logic [2:0] slot,
  input logic [5:0] strobe_o,
  input logic [6:0] seg_o
);
  // R2
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe_o));

  // R2
  wrap_to_msd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_n && scan_tick && slot == 3'd5) |=> (slot == 3'd0));

  // R3
  gap_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_n && scan_tick && GAP_CYC > 0) |=> (strobe_o == 6'b0 && seg_o == 7'b0));

  // R3
  seg_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_o != 7'b0) |-> (strobe_o != 6'b0));

  // R4
  slot_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_n && !scan_tick) |=> $stable(slot));

  // R8
  hold_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_n) |=> (strobe_o == 6'b100000));
endmodule

bind display_scanner scan_chk #(.GAP_CYC(GAP_CYC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scan_tick(scan_tick),
  .hold_n   (hold_n),
  .slot     (slot_q),
  .strobe_o (strobe_o),
  .seg_o    (seg_o)
);

// File: tb/sim_display_scanner.sv
`timescale 1ns/1ps
module sim_display_scanner;
  localparam int GAP = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scan_tick = 1'b0;
  logic        hold_n = 1'b1;
  logic        lz_off = 1'b0;
  logic [23:0] digits_i = '0;
  logic [5:0]  strobe_o;
  logic [3:0]  bcd_o;
  logic [6:0]  seg_o;

  int total = 0;
  int bad = 0;
  string req = "R1";

  // reference state
  int m_pos = 0;
  int m_gap = 0;
  int pat [10];

  always #2.5 clk = ~clk;

  display_scanner #(.GAP_CYC(GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick), .hold_n(hold_n),
    .lz_off(lz_off), .digits_i(digits_i),
    .strobe_o(strobe_o), .bcd_o(bcd_o), .seg_o(seg_o)
  );

  initial begin
    pat[0] = 'h3F; pat[1] = 'h06; pat[2] = 'h5B; pat[3] = 'h4F; pat[4] = 'h66;
    pat[5] = 'h6D; pat[6] = 'h7D; pat[7] = 'h07; pat[8] = 'h7F; pat[9] = 'h6F;
  end

  function automatic int digit_at(int pos);
    return int'((digits_i >> (4 * (5 - pos))) & 24'hF);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pos = 0; m_gap = 0;
    end else if (!hold_n) begin
      m_pos = 0; m_gap = 0;
    end else if (scan_tick) begin
      m_pos = (m_pos == 5) ? 0 : m_pos + 1;
      m_gap = GAP;
    end else if (m_gap > 0) begin
      m_gap = m_gap - 1;
    end
  end

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int d, es, est;
    bit all_zero;
    d = digit_at(m_pos);
    est = (m_gap > 0) ? 0 : (1 << (5 - m_pos));
    all_zero = 1;
    for (int p = 0; p <= m_pos; p++) if (digit_at(p) != 0) all_zero = 0;
    if (m_gap > 0 || !hold_n) es = 0;
    else if (!lz_off && m_pos != 5 && all_zero) es = 0;
    else if (d > 9) es = 0;
    else es = pat[d];
    check({req, " strobe"}, int'(strobe_o), est);
    check({req, " bcd"}, int'(bcd_o), d);
    check({req, " seg"}, int'(seg_o), es);
  endtask

  // one clock: compare at the falling edge, then set next inputs
  task automatic step(bit tk);
    @(negedge clk);
    compare_all();
    scan_tick = tk;
  endtask

  task automatic run_ticks(int n, int spacing);
    for (int i = 0; i < n; i++) begin
      step(1'b1);
      for (int j = 1; j < spacing; j++) step(1'b0);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    digits_i = 24'h407291;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    req = "R1";
    step(1'b0);
    check("R1 strobe at reset", int'(strobe_o), 'h20);
    check("R1 bcd at reset", int'(bcd_o), 4);

    // R2 R3 R4 R5 spaced ticks, full wrap twice
    req = "R2";
    run_ticks(13, 6);
    // R4: bcd shows new digit in first gap cycle
    req = "R4";
    step(1'b1);
    @(negedge clk);
    check("R4 bcd in gap", int'(bcd_o), digit_at(m_pos));
    check("R3 strobe dark in gap", int'(strobe_o), 0);
    compare_all();
    scan_tick = 1'b0;
    repeat (5) step(1'b0);

    // R3 ticks inside the gap and back to back
    req = "R3";
    run_ticks(7, 2);
    run_ticks(8, 1);
    repeat (6) step(1'b0);

    // R5 all ten codes
    req = "R5";
    digits_i = 24'h123456;
    run_ticks(12, 5);
    digits_i = 24'h789098;
    run_ticks(12, 5);

    // R6 leading zero suppression
    req = "R6";
    digits_i = 24'h000305;
    run_ticks(12, 5);
    digits_i = 24'h000000;
    run_ticks(12, 5);
    digits_i = 24'h100000;
    run_ticks(12, 5);
    digits_i = 24'h000000;
    // park on slot 5 and check LSD shown
    while (m_pos != 5) step(1'b1);
    repeat (GAP + 1) step(1'b0);
    check("R6 LSD zero shown", int'(seg_o), 'h3F);

    // R7 suppression disabled
    req = "R7";
    lz_off = 1'b1;
    digits_i = 24'h000305;
    run_ticks(12, 5);
    while (m_pos != 0) step(1'b1);
    repeat (GAP + 1) step(1'b0);
    check("R7 leading zero shown", int'(seg_o), 'h3F);
    lz_off = 1'b0;
    repeat (2) step(1'b0);
    check("R6 leading zero dark", int'(seg_o), 0);
    check("R7 bcd unaffected", int'(bcd_o), 0);

    // R8 hold in mid-scan with ticks
    req = "R8";
    digits_i = 24'h805612;
    run_ticks(3, 5);
    hold_n = 1'b0;
    run_ticks(6, 2);
    check("R8 parked strobe", int'(strobe_o), 'h20);
    check("R8 seg dark", int'(seg_o), 0);
    check("R8 bcd msd", int'(bcd_o), 8);
    @(negedge clk);
    hold_n = 1'b1;
    scan_tick = 1'b0;
    step(1'b1);
    repeat (GAP + 1) step(1'b0);
    check("R8 resume slot1", int'(strobe_o), 'h10);

    // R9 non-BCD codes
    req = "R9";
    digits_i = 24'hABCDEF;
    run_ticks(12, 5);
    digits_i = 24'h1F0A2B;
    run_ticks(12, 5);

    step(1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule